// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the configuration state of an interrupt router. Software reaches every register through two bus offsets: a select register that names the target, and a data window through which the named register is read or written. Behind the window sit an 8-bit identifier, a read-only version word, a reserved all-zero word, and a table of 64-bit routing entries. Each entry is reached as two 32-bit halves at consecutive select values.

The whole table is presented in parallel to the interrupt dispatcher. Each time software writes a valid half of an entry, the block raises a one-cycle notify pulse carrying the entry index, so the dispatcher can re-evaluate pending requests against the new routing. The bus is a single-cycle strobe interface: a write takes effect at the clock edge where `wr_en` is high, and read data appears on `rdata` in the cycle after `rd_en`. The data output holds its value until the next read.

Top module: `irq_route_regs`

## Requirements
- R1: Only bits 7:0 of `addr` are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. A read of any other offset returns 0, and a write to any other offset changes no state.
- R2: A write to offset 0x00 stores `wdata[7:0]` as the select value. A read of offset 0x00 returns that value in bits 7:0, with the upper bits zero.
- R3: With select 0x00, the window reads the 8-bit ID in bits 31:24, with all other bits zero. A window write loads the ID from `wdata[31:24]`.
- R4: With select 0x01, the window reads 0x00170011: the value 0x11 in bits 7:0 and NUM_ENTRIES-1 in bits 23:16. Writes are ignored.
- R5: Select 0x02, and select values 0x03 through 0x0F, read as 0 through the window and ignore writes.
- R6: A select value s of 0x10 or more addresses entry (s-0x10)>>1. When s is even the window reaches entry bits 31:0, and when s is odd it reaches bits 63:32.
- R7: A window write to one half of an entry leaves the other half, and all other entries, unchanged.
- R8: A select value that addresses an entry at or beyond NUM_ENTRIES reads as 0 and ignores writes.
- R9: Reset clears the ID, the select register and `rdata`. It sets every entry to 0x0000_0000_0001_0000, which is the masked value with only bit 16 set.
- R10: In the cycle after a window write to a valid entry half, `notify` is high for exactly one cycle and `notify_idx` holds the entry index. At that point `entries` already shows the new value. At all other times `notify` is low.
- R11: `entries` carries entry i at bits 64*i+63 down to 64*i, and changes only on window writes to valid entry halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Bus address; only bits 7:0 are decoded |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Single-cycle read strobe |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| entries | output | 64*NUM_ENTRIES | All routing entries, flattened |
| notify | output | 1 | One-cycle pulse after an entry half is written |
| notify_idx | output | $clog2(NUM_ENTRIES) | Index of the entry just written |

## Verification
The table is driven straight onto `entries`, so a corrupted half-merge or a wrong index decode shows on the very next cycle as a mismatch in a neighbouring half or entry. The bench compares the full table against its model on every clock. A wrongly held select value or ID stays hidden until software reads it back, so the bench reads the select register, the ID, the version and both halves of entries after each group of writes, including aliased addresses and out-of-range selects. Notify faults appear in the cycle right after the write that caused them.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int NUM_ENTRIES = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [31:0]                   addr,
  input  logic                          wr_en,
  input  logic [31:0]                   wdata,
  input  logic                          rd_en,
  output logic [31:0]                   rdata,
  output logic [64*NUM_ENTRIES-1:0]     entries,
  output logic                          notify,
  output logic [$clog2(NUM_ENTRIES)-1:0] notify_idx
);
  localparam int IDXW = $clog2(NUM_ENTRIES);
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] TBL_BASE = 8'h10;
  localparam logic [63:0] MASKED = 64'h1_0000;

  logic [7:0]  sel_q;
  logic [7:0]  id_q;
  logic [63:0] tbl [NUM_ENTRIES];

  wire       hit_sel = addr[7:0] == OFS_SEL;
  wire       hit_win = addr[7:0] == OFS_WIN;
  wire [7:0] ent_off = sel_q - TBL_BASE;
  wire [6:0] ent_num = ent_off[7:1];
  wire       ent_ok  = (sel_q >= TBL_BASE) && (int'(ent_num) < NUM_ENTRIES);
  wire [IDXW-1:0] ent_idx = IDXW'(ent_num);
  wire       ent_wr  = wr_en && hit_win && ent_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (wr_en && hit_sel) begin
      sel_q <= wdata[7:0];
    end else if (wr_en && hit_win && sel_q == 8'h00) begin
      id_q <= wdata[31:24];
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[i] <= MASKED;
      else if (ent_wr && ent_idx == IDXW'(i)) begin
        if (sel_q[0]) tbl[i][63:32] <= wdata;
        else          tbl[i][31:0]  <= wdata;
      end
    end
    assign entries[64*i +: 64] = tbl[i];
  end

  logic [31:0] win_val;
  always_comb begin
    win_val = '0;
    case (sel_q)
      8'h00: win_val = {id_q, 24'h0};
      8'h01: win_val = {8'h0, 8'(NUM_ENTRIES - 1), 8'h0, VERSION};
      default:
        if (ent_ok)
          win_val = sel_q[0] ? tbl[ent_idx][63:32] : tbl[ent_idx][31:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata      <= '0;
      notify     <= 1'b0;
      notify_idx <= '0;
    end else begin
      if (rd_en)
        rdata <= hit_sel ? {24'h0, sel_q} : hit_win ? win_val : 32'h0;
      notify <= ent_wr;
      if (ent_wr) notify_idx <= ent_idx;
    end
  end

  p_notify_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> $past(wr_en && addr[7:0] == OFS_WIN));
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_sel) |=> $stable(sel_q));
  p_id_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_win) |=> $stable(id_q));
  p_tbl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit_win) |=> $stable(entries));
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/irq_route_regs_tb.sv
module irq_route_regs_tb_top;
  localparam int N = 24;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic rd_en = 1'b0;
  logic [31:0] rdata;
  logic [64*N-1:0] entries;
  logic notify;
  logic [IW-1:0] notify_idx;

  always #2.5 clk = ~clk;

  irq_route_regs #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .entries(entries), .notify(notify),
    .notify_idx(notify_idx));

  int vectors = 0;
  int miscompares = 0;
  logic [7:0]  m_sel;
  logic [7:0]  m_id;
  logic [63:0] m_tbl [N];
  logic [31:0] m_rdata;
  logic        m_notify;
  logic [IW-1:0] m_idx;

  function automatic logic [31:0] m_read(logic [31:0] a);
    int s, e;
    if (a[7:0] == 8'h00) return {24'h0, m_sel};
    if (a[7:0] != 8'h10) return 32'h0;
    s = m_sel;
    if (s == 0) return {m_id, 24'h0};
    if (s == 1) return 32'h0017_0011;
    if (s < 16) return 32'h0;
    e = (s - 16) / 2;
    if (e >= N) return 32'h0;
    return (s % 2 == 1) ? m_tbl[e][63:32] : m_tbl[e][31:0];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(string rreq);
    chk(rreq, {32'h0, rdata}, {32'h0, m_rdata});
    chk("R10 notify", {63'h0, notify}, {63'h0, m_notify});
    if (m_notify) chk("R10 idx", {{(64-IW){1'b0}}, notify_idx}, {{(64-IW){1'b0}}, m_idx});
    for (int i = 0; i < N; i++) chk("R7/R11 entry", entries[64*i +: 64], m_tbl[i]);
  endtask

  task automatic step(bit w, bit r, logic [31:0] a, logic [31:0] d, string rreq);
    int s, e;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    if (r) m_rdata = m_read(a);
    m_notify = 1'b0;
    if (w) begin
      if (a[7:0] == 8'h00) m_sel = d[7:0];
      else if (a[7:0] == 8'h10) begin
        s = m_sel;
        if (s == 0) m_id = d[31:24];
        else if (s >= 16 && (s - 16) / 2 < N) begin
          e = (s - 16) / 2;
          if (s % 2 == 1) m_tbl[e][63:32] = d; else m_tbl[e][31:0] = d;
          m_notify = 1'b1;
          m_idx = IW'(e);
        end
      end
    end
    @(posedge clk);
    #1;
    compare_all(rreq);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d); step(1, 0, a, d, "R1 rdata"); endtask
  task automatic rd(logic [31:0] a, string req);     step(0, 1, a, 0, req); endtask
  task automatic selrd(logic [7:0] s, string req);
    wr(32'h0, {24'h0, s});
    rd(32'h10, req);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_sel = 0; m_id = 0; m_rdata = 0; m_notify = 0; m_idx = 0;
    for (int i = 0; i < N; i++) m_tbl[i] = 64'h1_0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 compare_all("R9 reset rdata");
    rd(32'h0, "R9 sel reset");
    rd(32'h10, "R9 id reset");
    selrd(8'h11, "R9 entry0 hi");
    selrd(8'h3E, "R9 entry23 lo");
    selrd(8'h01, "R4 version");
    wr(32'h10, 32'hFFFF_FFFF);
    rd(32'h10, "R4 write ignored");
    selrd(8'h02, "R5 zero");
    wr(32'h10, 32'h1234_5678);
    rd(32'h10, "R5 write ignored");
    selrd(8'h07, "R5 gap");
    wr(32'h0, 32'hABCD_EF5A);
    rd(32'h0, "R2 sel readback");
    wr(32'h0, 32'h0);
    wr(32'h10, 32'hA5FF_FFFF);
    rd(32'h10, "R3 id");
    rd(32'hFEC0_0010, "R1 alias win");
    rd(32'h04, "R1 other offset");
    wr(32'h0000_0104, 32'hFFFF_FFFF);
    rd(32'h10, "R1 write other offset ignored");
    wr(32'h0000_0300, 32'h0000_0012);
    rd(32'h0, "R1 alias sel");
    wr(32'h10, 32'hDEAD_BEEF);
    rd(32'h10, "R6 entry1 lo");
    wr(32'h0, 32'h13);
    wr(32'h10, 32'h0102_0304);
    rd(32'h10, "R6 entry1 hi");
    selrd(8'h12, "R7 lo kept");
    wr(32'h0, 32'h10);
    wr(32'h10, 32'h0000_0031);
    wr(32'h0, 32'h3F);
    wr(32'h10, 32'hFF00_0000);
    rd(32'h10, "R6 entry23 hi");
    selrd(8'h3E, "R7 entry23 lo kept");
    wr(32'h0, 32'h40);
    wr(32'h10, 32'h5555_5555);
    rd(32'h10, "R8 past end");
    selrd(8'hFF, "R8 top select");
    wr(32'h10, 32'h7777_7777);
    for (int k = 0; k < N; k++) begin
      wr(32'h0, 32'h10 + 2 * k);
      wr(32'h10, 32'hC000_0000 + k);
      rd(32'h10, "R6 sweep");
    end
    step(1, 0, 32'h10, 32'h0, "R1 rdata");
    step(0, 0, 32'h0, 32'h0, "R10 quiet");
    step(0, 0, 32'h0, 32'h0, "R10 quiet");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule